// File: doc/BRIEF.md
# Serial Link Receiver Back End with Link Self-Test Checker

This block is the byte-rate back end of an 8B/10B serial receiver. A decoder ahead of it hands over one character per cycle of the recovered byte clock. Each character arrives as a decoded byte, a control-character flag, a code-error flag, a disparity-error flag, a null-pad indication and the raw 10-bit word. The block registers the character onto a parallel data output, a control/data flag, a violation flag and an active-low ready strobe. All four outputs change together, one byte clock after the character is presented. The ready strobe is withheld for null pad characters, so a downstream FIFO writes only real payload.

In link self-test mode the block regenerates the test loop that the far-end transmitter sends. A test loop is a start control character followed by a pseudo-random run of data bytes. The block compares every received character against its local copy and reports the result byte by byte on the violation output. In this mode the ready output is inverted: it stays low and rises for a single byte time on the last byte of each loop. The checker aligns to the loop when it sees the start character and flags every byte as bad until then. A bypass mode skips all interpretation and spreads the raw 10-bit word across the outputs.

Top module: `lrx_backend`

## Requirements
- R1: While rst_n is low the outputs are q_data=0, q_special=0, q_viol=0, q_rdy_n=1. After reset, all four outputs update together on the rising clk edge that captures the input character, so they show the character presented in the previous cycle.
- R2: Normal mode (bypass_en=0, bist_en=0) and self-test mode (bist_en=1, bypass_en=0): q_data carries dec_byte and q_special carries dec_special (1 = control character, 0 = data).
- R3: Normal mode: q_viol is 1 exactly for a character whose dec_code_err or dec_disp_err is 1, and returns to 0 on the next clean character.
- R4: Normal mode: q_rdy_n is 0 for each character with dec_null=0 and 1 for a null pad (dec_null=1).
- R5: Bypass mode (bypass_en=1, which overrides bist_en): q_special=raw_word[9], q_data[7:0]=raw_word[8:1] (raw_word[8] on q_data[7]), q_viol=raw_word[0], and q_rdy_n=0 for every character.
- R6: Self-test mode: q_rdy_n is 1 only for the character at loop position 15 (the last of a 16-character loop) of a synchronised checker, and 0 for every other character.
- R7: Self-test loop content: position 0 is the control character 0xBC. Positions 1 to 15 are data characters whose values come from an 8-bit register seeded with 0x01 at position 1 and advanced once per position by next = {r[6:0], r[7]^r[5]^r[4]^r[3]}.
- R8: Self-test mode, synchronised: q_viol is 0 when the character equals the expected value and flag with no code or disparity error, and 1 otherwise. A mismatch does not lose the loop position.
- R9: A clean 0xBC control character in self-test mode always reports q_viol=0 and places the checker at position 1 for the next character, even mid-loop. Until the first such character after entering self-test mode (or after bypass or leaving self-test), every character reports q_viol=1 and q_rdy_n=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass_en | input | 1 | Raw 10-bit pass-through mode |
| bist_en | input | 1 | Link self-test mode |
| dec_byte | input | 8 | Decoded character value |
| dec_special | input | 1 | Decoded character is a control character |
| dec_code_err | input | 1 | Character is not in the valid code table |
| dec_disp_err | input | 1 | Character breaks running-disparity rules |
| dec_null | input | 1 | Character is the null pad |
| raw_word | input | 10 | Undecoded 10-bit character, bit 9 first |
| q_data | output | 8 | Registered data output |
| q_special | output | 1 | Control/data flag, or raw bit 9 in bypass |
| q_viol | output | 1 | Violation or self-test mismatch, or raw bit 0 in bypass |
| q_rdy_n | output | 1 | Active-low ready strobe |

## Verification
The assertions take for granted that every input is a defined value after reset and holds steady between rising edges, with exactly one character offered per clock. They also assume the mode pins are sampled with the character they accompany. The stimulus changes inputs only on falling edges, so each character and its mode settle half a cycle before capture. It also switches modes only between characters. In self-test runs the bench builds its loops from its own copy of the sequence rule. It corrupts chosen positions deliberately, leaving other decoder flags at values the self-test path must still judge.

// File: rtl/lrx_pkg.sv
// Shared types for the serial receiver back end.
// Assumes an 8-bit decoded character width; the struct is the registered
// output bundle that every output path produces.
package lrx_pkg;

    localparam int unsigned LRX_DW = 8;

    // One registered output character.
    typedef struct packed {
        logic [LRX_DW-1:0] data;
        logic              special;
        logic              viol;
        logic              rdy_n;
    } lrx_out_t;

    // Operating mode selected per character.
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_BIST   = 2'd1,
        MODE_BYPASS = 2'd2
    } lrx_mode_e;

endpackage

// File: rtl/lrx_bist_check.sv
// Self-test loop checker.
// Regenerates the transmitter's test loop locally and judges each received
// character against it. Synchronises on a clean start control character.
// Assumes one character per clock while active; clears its state whenever
// inactive so that re-entry starts unsynchronised.
module lrx_bist_check #(
    parameter int unsigned       DW         = 8,
    parameter int unsigned       LOOP_LEN   = 16,
    parameter logic [DW-1:0]     START_CHAR = 8'hBC,
    parameter logic [DW-1:0]     SEED       = 8'h01,
    parameter logic [DW-1:0]     TAPS       = 8'hB8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [DW-1:0] chr,
    input  logic          chr_special,
    input  logic          chr_err,
    output logic          mismatch,
    output logic          loop_last
);

    localparam int unsigned IW   = (LOOP_LEN > 2) ? $clog2(LOOP_LEN) : 1;
    localparam logic [IW-1:0] LAST = IW'(LOOP_LEN - 1);
    localparam logic [IW-1:0] ONE  = IW'(1);

    logic          synced_q, synced_d;
    logic [IW-1:0] pos_q, pos_d;
    logic [DW-1:0] seq_q, seq_d;
    logic          is_start;
    logic          at_head;
    logic [DW-1:0] exp_chr;
    logic          exp_special;
    logic          match;

    // Advance the sequence register by one position.
    function automatic logic [DW-1:0] seq_step(input logic [DW-1:0] r);
        return {r[DW-2:0], ^(r & TAPS)};
    endfunction

    // Decode what the current character should be and judge it.
    always_comb begin
        is_start    = chr_special && (chr == START_CHAR) && !chr_err;
        at_head     = (pos_q == '0);
        exp_chr     = at_head ? START_CHAR : seq_q;
        exp_special = at_head;
        match       = synced_q && (chr == exp_chr) &&
                      (chr_special == exp_special) && !chr_err;
        mismatch    = !(is_start || match);
        loop_last   = synced_q && !is_start && (pos_q == LAST);
    end

    // Compute next loop position, sync state and expected sequence value.
    always_comb begin
        synced_d = synced_q;
        pos_d    = pos_q;
        seq_d    = seq_q;
        if (!active) begin
            synced_d = 1'b0;
            pos_d    = '0;
            seq_d    = SEED;
        end else if (is_start) begin
            synced_d = 1'b1;
            pos_d    = (LOOP_LEN > 1) ? ONE : '0;
            seq_d    = SEED;
        end else if (synced_q) begin
            pos_d = (pos_q == LAST) ? '0 : pos_q + ONE;
            seq_d = at_head ? SEED : seq_step(seq_q);
        end
    end

    // Hold checker state across characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q <= 1'b0;
            pos_q    <= '0;
            seq_q    <= SEED;
        end else begin
            synced_q <= synced_d;
            pos_q    <= pos_d;
            seq_q    <= seq_d;
        end
    end

endmodule

// File: rtl/lrx_out_mux.sv
// Output selection for one character.
// Builds the next output bundle from the decoded character, the raw word
// or the self-test verdict according to the mode. Purely combinational;
// assumes the raw word is DW+2 bits with its first bit in the MSB.
module lrx_out_mux
    import lrx_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  lrx_mode_e     mode,
    input  logic [DW-1:0] dec_byte,
    input  logic          dec_special,
    input  logic          dec_err,
    input  logic          dec_null,
    input  logic [DW+1:0] raw_word,
    input  logic          bist_mismatch,
    input  logic          bist_last,
    output lrx_out_t      nxt
);

    logic [DW-1:0] raw_mid;

    // Middle raw bits map one-for-one onto the data output.
    for (genvar i = 0; i < DW; i++) begin : g_raw_mid
        assign raw_mid[i] = raw_word[i+1];
    end

    // Pick the output bundle for the current mode.
    always_comb begin
        nxt = '0;
        unique case (mode)
            MODE_BYPASS: begin
                nxt.data    = raw_mid;
                nxt.special = raw_word[DW+1];
                nxt.viol    = raw_word[0];
                nxt.rdy_n   = 1'b0;
            end
            MODE_BIST: begin
                nxt.data    = dec_byte;
                nxt.special = dec_special;
                nxt.viol    = bist_mismatch;
                nxt.rdy_n   = bist_last;
            end
            default: begin
                nxt.data    = dec_byte;
                nxt.special = dec_special;
                nxt.viol    = dec_err;
                nxt.rdy_n   = dec_null;
            end
        endcase
    end

endmodule

// File: rtl/lrx_out_reg.sv
// Output register stage.
// Captures the output bundle on the byte clock so that all outputs switch
// together. Reset leaves the ready strobe inactive (high).
module lrx_out_reg
    import lrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lrx_out_t nxt,
    output lrx_out_t cur
);

    localparam lrx_out_t RST_VAL = '{data: '0, special: 1'b0, viol: 1'b0, rdy_n: 1'b1};

    // Register the bundle, forcing the idle value during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= RST_VAL;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/lrx_backend.sv
// Serial link receiver back end.
// Takes one decoded character per recovered byte clock and drives the
// registered parallel outputs, with a bypass mode for raw words and a
// self-test mode that checks the far end's test loop. Assumes the decoder
// supplies all character fields in the same cycle.
module lrx_backend
    import lrx_pkg::*;
#(
    parameter int unsigned   DW         = LRX_DW,
    parameter int unsigned   LOOP_LEN   = 16,
    parameter logic [DW-1:0] START_CHAR = 8'hBC,
    parameter logic [DW-1:0] SEED       = 8'h01,
    parameter logic [DW-1:0] TAPS       = 8'hB8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bypass_en,
    input  logic          bist_en,
    input  logic [DW-1:0] dec_byte,
    input  logic          dec_special,
    input  logic          dec_code_err,
    input  logic          dec_disp_err,
    input  logic          dec_null,
    input  logic [DW+1:0] raw_word,
    output logic [DW-1:0] q_data,
    output logic          q_special,
    output logic          q_viol,
    output logic          q_rdy_n
);

    lrx_mode_e mode;
    logic      dec_err;
    logic      bist_mismatch;
    logic      bist_last;
    lrx_out_t  nxt;
    lrx_out_t  cur;

    // Resolve the mode: bypass wins over self-test.
    always_comb begin
        if (bypass_en)    mode = MODE_BYPASS;
        else if (bist_en) mode = MODE_BIST;
        else              mode = MODE_NORMAL;
        dec_err = dec_code_err | dec_disp_err;
    end

    lrx_bist_check #(
        .DW(DW), .LOOP_LEN(LOOP_LEN), .START_CHAR(START_CHAR),
        .SEED(SEED), .TAPS(TAPS)
    ) u_bist (
        .clk(clk), .rst_n(rst_n), .active(mode == MODE_BIST),
        .chr(dec_byte), .chr_special(dec_special), .chr_err(dec_err),
        .mismatch(bist_mismatch), .loop_last(bist_last)
    );

    lrx_out_mux #(.DW(DW)) u_mux (
        .mode(mode), .dec_byte(dec_byte), .dec_special(dec_special),
        .dec_err(dec_err), .dec_null(dec_null), .raw_word(raw_word),
        .bist_mismatch(bist_mismatch), .bist_last(bist_last), .nxt(nxt)
    );

    lrx_out_reg u_oreg (.clk(clk), .rst_n(rst_n), .nxt(nxt), .cur(cur));

    // Break the bundle out onto the ports.
    always_comb begin
        q_data    = cur.data;
        q_special = cur.special;
        q_viol    = cur.viol;
        q_rdy_n   = cur.rdy_n;
    end

endmodule

// File: rtl/lrx_backend_chk.sv
// Assertion checker for the receiver back end, bound to every instance.
// Assumes inputs are defined after reset and stable between edges.
module lrx_backend_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bypass_en,
    input logic          bist_en,
    input logic [DW-1:0] dec_byte,
    input logic          dec_special,
    input logic          dec_code_err,
    input logic          dec_disp_err,
    input logic          dec_null,
    input logic [DW+1:0] raw_word,
    input logic [DW-1:0] q_data,
    input logic          q_special,
    input logic          q_viol,
    input logic          q_rdy_n
);

    logic armed;
    logic norm_mode;
    logic bist_mode;

    // Mark the first edge after reset so $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign norm_mode = !bypass_en && !bist_en;
    assign bist_mode = !bypass_en && bist_en;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (q_rdy_n && !q_viol && !q_special && q_data == '0)); // R1

    AST_NORM_PASS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(norm_mode) |-> (q_data == $past(dec_byte) && q_special == $past(dec_special))); // R2

    AST_NORM_VIOL: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(norm_mode) |-> (q_viol == ($past(dec_code_err) || $past(dec_disp_err)))); // R3

    AST_NULL_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(norm_mode) |-> (q_rdy_n == $past(dec_null))); // R4

    AST_BYPASS_MAP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(bypass_en) |-> (q_special == $past(raw_word[DW+1]) && q_viol == $past(raw_word[0])
                              && q_data == $past(raw_word[DW:1]) && !q_rdy_n)); // R5

    AST_BIST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (bist_mode && $past(bist_mode) && q_rdy_n) |=> !q_rdy_n); // R6

    AST_BIST_START_OK: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(bist_mode) && $past(dec_special) && $past(dec_byte) == 8'hBC
         && !$past(dec_code_err) && !$past(dec_disp_err)) |-> (!q_viol && !q_rdy_n)); // R9

    AST_BIST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(bist_mode) && ($past(dec_code_err) || $past(dec_disp_err))) |-> q_viol); // R8

endmodule

bind lrx_backend lrx_backend_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .bist_en(bist_en),
    .dec_byte(dec_byte), .dec_special(dec_special), .dec_code_err(dec_code_err),
    .dec_disp_err(dec_disp_err), .dec_null(dec_null), .raw_word(raw_word),
    .q_data(q_data), .q_special(q_special), .q_viol(q_viol), .q_rdy_n(q_rdy_n)
);

// File: tb/test_lrx_backend.sv
module test_lrx_backend;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bypass_en, bist_en;
    logic [7:0] dec_byte;
    logic       dec_special, dec_code_err, dec_disp_err, dec_null;
    logic [9:0] raw_word;
    logic [7:0] q_data;
    logic       q_special, q_viol, q_rdy_n;

    always #5 clk = ~clk;

    lrx_backend i_lrx_backend (
        .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .bist_en(bist_en),
        .dec_byte(dec_byte), .dec_special(dec_special), .dec_code_err(dec_code_err),
        .dec_disp_err(dec_disp_err), .dec_null(dec_null), .raw_word(raw_word),
        .q_data(q_data), .q_special(q_special), .q_viol(q_viol), .q_rdy_n(q_rdy_n)
    );

    typedef struct {
        int    d, sc, v, r;
        string td, tv, tr;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    int   m_sync = 0;
    int   m_pos  = 0;
    int   m_seq  = 1;

    // Sequence rule of R7, in integer form.
    function automatic int seq_next(int r);
        int fb;
        fb = ((r >> 7) ^ (r >> 5) ^ (r >> 4) ^ (r >> 3)) & 1;
        return ((r << 1) & 255) | fb;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model: expected outputs for the character now on the inputs.
    task automatic model();
        exp_t e;
        int   err;
        if (bypass_en) begin
            e.d = int'(raw_word[8:1]); e.sc = raw_word[9]; e.v = raw_word[0]; e.r = 0;
            e.td = "R5"; e.tv = "R5"; e.tr = "R5";
            m_sync = 0;
        end else if (bist_en) begin
            err  = (dec_code_err || dec_disp_err) ? 1 : 0;
            e.d  = dec_byte; e.sc = dec_special; e.td = "R2"; e.tr = "R6";
            if (dec_special && dec_byte == 8'hBC && err == 0) begin
                e.v = 0; e.r = 0; e.tv = "R9";
                m_sync = 1; m_pos = 1; m_seq = 1;
            end else if (m_sync != 0) begin
                int eb, es;
                eb  = (m_pos == 0) ? 'hBC : m_seq;
                es  = (m_pos == 0) ? 1 : 0;
                e.v = (dec_byte == eb && dec_special == es && err == 0) ? 0 : 1;
                e.r = (m_pos == 15) ? 1 : 0;
                e.tv = "R8";
                m_seq = (m_pos == 0) ? 1 : seq_next(m_seq);
                m_pos = (m_pos == 15) ? 0 : m_pos + 1;
            end else begin
                e.v = 1; e.r = 0; e.tv = "R9";
            end
        end else begin
            e.d = dec_byte; e.sc = dec_special;
            e.v = (dec_code_err || dec_disp_err) ? 1 : 0;
            e.r = dec_null; e.td = "R2"; e.tv = "R3"; e.tr = "R4";
            m_sync = 0;
        end
        expq.push_back(e);
    endtask

    // Present the current inputs for one clock and compare at the next falling edge.
    task automatic apply();
        exp_t e;
        model();
        @(negedge clk);
        e = expq.pop_front();
        check(e.td, "q_data", int'(q_data), e.d);
        check(e.td, "q_special", int'(q_special), e.sc);
        check(e.tv, "q_viol", int'(q_viol), e.v);
        check(e.tr, "q_rdy_n", int'(q_rdy_n), e.r);
    endtask

    task automatic send_dec(int b, int sc, int ce, int de, int nl);
        dec_byte = 8'(b); dec_special = sc[0]; dec_code_err = ce[0];
        dec_disp_err = de[0]; dec_null = nl[0]; raw_word = 10'($urandom);
        apply();
    endtask

    task automatic send_raw(int raw);
        raw_word = 10'(raw); dec_byte = 8'($urandom); dec_special = 1'($urandom);
        dec_code_err = 1'b0; dec_disp_err = 1'b0; dec_null = 1'($urandom);
        apply();
    endtask

    // One full self-test loop; bad_pos corrupts a value, err_pos flags a decode error.
    task automatic send_loop(int bad_pos, int err_pos, int len);
        int l;
        l = 1;
        for (int i = 0; i < len; i++) begin
            int b;
            b = (i == 0) ? 'hBC : l;
            if (i == bad_pos) b = b ^ 'h10;
            send_dec(b, (i == 0) ? 1 : 0, (i == err_pos) ? 1 : 0, 0, 0);
            if (i >= 1) l = seq_next(l);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bypass_en = 1'b0; bist_en = 1'b0;
        dec_byte = 8'h5A; dec_special = 1'b1; dec_code_err = 1'b1;
        dec_disp_err = 1'b0; dec_null = 1'b0; raw_word = 10'h3FF;
        repeat (3) @(negedge clk);
        // R1: idle values during reset despite busy inputs
        check("R1", "reset q_data", int'(q_data), 0);
        check("R1", "reset q_special", int'(q_special), 0);
        check("R1", "reset q_viol", int'(q_viol), 0);
        check("R1", "reset q_rdy_n", int'(q_rdy_n), 1);
        rst_n = 1'b1;

        // R2 R3 R4: directed normal-mode characters
        send_dec('hA5, 0, 0, 0, 0);
        send_dec('hBC, 1, 0, 0, 0);
        send_dec('h33, 0, 1, 0, 0);
        send_dec('h34, 0, 0, 0, 0);   // R3 violation clears on next clean byte
        send_dec('h35, 0, 0, 1, 0);
        send_dec('h00, 1, 0, 0, 1);   // R4 null pad: no ready
        send_dec('h00, 1, 0, 0, 1);
        send_dec('h7E, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++)
            send_dec($urandom, $urandom % 2, ($urandom % 5) == 0, ($urandom % 7) == 0,
                     ($urandom % 3) == 0);

        // R5: bypass field mapping
        bypass_en = 1'b1;
        send_raw(10'b10_0000_0001);
        send_raw(10'b01_1111_1110);
        send_raw(10'b00_1000_0000);
        for (int i = 0; i < 20; i++) send_raw($urandom);
        bypass_en = 1'b0;

        // R9: unsynchronised self-test reports every byte
        bist_en = 1'b1;
        send_dec('h01, 0, 0, 0, 0);
        send_dec('hBC, 1, 1, 0, 0);   // start with decode error does not sync
        send_dec('h55, 0, 0, 0, 0);
        // R6 R7 R8: clean loops
        send_loop(-1, -1, 16);
        send_loop(-1, -1, 16);
        send_loop(5, 9, 16);          // R8 value mismatch and decode error
        send_dec('h01, 0, 0, 0, 0);   // R8 head position wrong
        send_loop(16, -1, 16);        // shifted: continues at position 1
        send_loop(-1, -1, 6);         // R9 restart mid-loop
        send_loop(-1, -1, 16);
        send_loop(-1, -1, 16);

        // R5 bypass overrides self-test and drops sync (R9)
        bypass_en = 1'b1;
        send_raw(10'h2AA);
        send_raw(10'h155);
        bypass_en = 1'b0;
        send_dec('h02, 0, 0, 0, 0);
        send_loop(-1, -1, 16);
        // leaving self-test drops sync
        bist_en = 1'b0;
        send_dec('h11, 0, 0, 0, 0);
        bist_en = 1'b1;
        send_dec('h01, 0, 0, 0, 0);
        send_loop(-1, 3, 16);
        bist_en = 1'b0;
        send_dec('h22, 0, 0, 0, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule